// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two W-bit buses, called side A and side B, and can move data between them in either direction. Each direction has its own capture register with its own rising-edge clock, its own source select and its own output enable. For each direction the block drives one of two sources onto the far bus: the live value from the opposite bus, or the value that direction's register holds. The capture registers load on every rising edge of their clock, whatever the selects and enables are doing. A register can therefore take in fresh bus data while the same direction is already driving its previously stored value.

Each bus side is exposed as split ports: an input carrying the resolved bus value, an output carrying the value the block drives, and a drive flag. The enclosing level turns these into the shared wire and feeds the resolved value back on the input port. When a bus is driven by the block, its input port therefore shows the driven value, and a capture on that side stores what the block itself is driving.

Enabling both directions with both selects on live data makes each bus drive the other. With no other driver present, this loop keeps both buses at their last value. The parameter INVERT selects a variant that complements every driven bit and leaves all control behaviour unchanged. All pins are level-sensitive or edge-sensitive control. No data stream or back-pressure applies here, so there is no valid/ready handshake.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: On every rising edge of `ab_cap_clk`, the A-to-B register loads `a_in`, whatever `ab_sel`, `ba_sel`, `b_drive` and `a_drive_n` are doing.
- R2: On every rising edge of `ba_cap_clk`, the B-to-A register loads `b_in`, whatever the selects and enables are doing. This includes the case where side A is driving the register's previous content.
- R3: With a select low (0 = live), the matching output follows the opposite bus combinationally, with no register stage: `b_out` follows `a_in` and `a_out` follows `b_in`.
- R4: With a select high (1 = stored), the matching output shows that direction's register: `b_out` shows the A-to-B register and `a_out` shows the B-to-A register.
- R5: `b_oe` is high exactly when `b_drive` is high (active-high enable). `a_oe` is high exactly when `a_drive_n` is low (active-low enable).
- R6: With `b_drive` low and `a_drive_n` high, neither side is driven (`a_oe` = `b_oe` = 0), and both registers still capture on their clock edges.
- R7: With both enables active and both selects low, `a_out` equals `b_in` and `b_out` equals `a_in`, so a bus value fed back to the block is held unchanged on both sides.
- R8: With both enables active and both selects high, `a_out` shows the B-to-A register and `b_out` shows the A-to-B register at the same time.
- R9: With INVERT = 1, every driven output bit is the complement of the value the same inputs give with INVERT = 0, and `a_oe` and `b_oe` are identical in both variants.
- R10: While `rst_n` is low, both registers are cleared to zero asynchronously.
- R11: A data output whose side is not enabled reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| ab_cap_clk | input | 1 | Rising-edge capture clock of the A-to-B register |
| ba_cap_clk | input | 1 | Rising-edge capture clock of the B-to-A register |
| ab_sel | input | 1 | Source for side B: 0 live `a_in`, 1 A-to-B register |
| ba_sel | input | 1 | Source for side A: 0 live `b_in`, 1 B-to-A register |
| b_drive | input | 1 | Active-high enable for driving side B |
| a_drive_n | input | 1 | Active-low enable for driving side A |
| a_in | input | W | Resolved value of bus A |
| a_out | output | W | Value the block drives on bus A |
| a_oe | output | 1 | Block drives bus A |
| b_in | input | W | Resolved value of bus B |
| b_out | output | W | Value the block drives on bus B |
| b_oe | output | 1 | Block drives bus B |

## Verification
The bench builds two instances with W = 8: one with INVERT = 0 and one with INVERT = 1. Both receive the same stimulus, so every vector checks the complemented outputs and the unchanged drive flags against the plain results, which brings R9 within reach. The bench acts as the bus resolver. It feeds the block's own driven value back on the input ports, so the bus-hold fixed point and the capture of a self-driven value both become visible at the ports.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_e;

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         cap_clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Loads unconditionally on each rising capture edge.
  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/xcvr_drive_lane.sv
module xcvr_drive_lane
  import xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  input  logic         sel,
  input  logic         en,
  output logic [W-1:0] dout,
  output logic         oe
);

  logic [W-1:0] picked;

  always_comb begin
    unique case (src_e'(sel))
      SRC_HELD: picked = held;
      default:  picked = live;
    endcase
  end

  generate
    if (INVERT) begin : g_inv
      assign dout = en ? ~picked : '0;
    end else begin : g_true
      assign dout = en ? picked : '0;
    end
  endgenerate

  assign oe = en;

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         rst_n,
  input  logic         ab_cap_clk,
  input  logic         ba_cap_clk,
  input  logic         ab_sel,
  input  logic         ba_sel,
  input  logic         b_drive,
  input  logic         a_drive_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  logic [W-1:0] ab_q;
  logic [W-1:0] ba_q;
  logic         a_en;

  // Side A enable is active low; normalise to active high.
  assign a_en = ~a_drive_n;

  xcvr_store_reg #(.W(W)) u_ab_reg (
    .cap_clk (ab_cap_clk),
    .rst_n   (rst_n),
    .d       (a_in),
    .q       (ab_q)
  );

  xcvr_store_reg #(.W(W)) u_ba_reg (
    .cap_clk (ba_cap_clk),
    .rst_n   (rst_n),
    .d       (b_in),
    .q       (ba_q)
  );

  xcvr_drive_lane #(.W(W), .INVERT(INVERT)) u_to_b (
    .live (a_in),
    .held (ab_q),
    .sel  (ab_sel),
    .en   (b_drive),
    .dout (b_out),
    .oe   (b_oe)
  );

  xcvr_drive_lane #(.W(W), .INVERT(INVERT)) u_to_a (
    .live (b_in),
    .held (ba_q),
    .sel  (ba_sel),
    .en   (a_en),
    .dout (a_out),
    .oe   (a_oe)
  );

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         rst_n,
  input logic         ab_cap_clk,
  input logic         ba_cap_clk,
  input logic         ab_sel,
  input logic         ba_sel,
  input logic         b_drive,
  input logic         a_drive_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe
);

  logic [W-1:0] pol;
  logic [W-1:0] seen_a;
  logic [W-1:0] seen_b;

  assign pol = INVERT ? '1 : '0;

  // Independent record of the last value present at each capture edge.
  always_ff @(posedge ab_cap_clk or negedge rst_n) begin
    if (!rst_n) seen_a <= '0;
    else        seen_a <= a_in;
  end

  always_ff @(posedge ba_cap_clk or negedge rst_n) begin
    if (!rst_n) seen_b <= '0;
    else        seen_b <= b_in;
  end

  AST_HELD_AB: assert property (@(posedge ab_cap_clk) disable iff (!rst_n)
    (b_drive && ab_sel) |-> (b_out == (seen_a ^ pol))); // R1

  AST_HELD_BA: assert property (@(posedge ba_cap_clk) disable iff (!rst_n)
    (!a_drive_n && ba_sel) |-> (a_out == (seen_b ^ pol))); // R2

  AST_LIVE_AB: assert property (@(posedge ab_cap_clk) disable iff (!rst_n)
    (b_drive && !ab_sel) |-> (b_out == (a_in ^ pol))); // R3

  AST_LIVE_BA: assert property (@(posedge ba_cap_clk) disable iff (!rst_n)
    (!a_drive_n && !ba_sel) |-> (a_out == (b_in ^ pol))); // R3

  AST_QUIET_A: assert property (@(posedge ba_cap_clk) disable iff (!rst_n)
    a_drive_n |-> (!a_oe && a_out == '0)); // R11

  AST_QUIET_B: assert property (@(posedge ab_cap_clk) disable iff (!rst_n)
    !b_drive |-> (!b_oe && b_out == '0)); // R11

endmodule

bind bidir_reg_xcvr xcvr_checker #(.W(W), .INVERT(INVERT)) u_chk (
  .rst_n      (rst_n),
  .ab_cap_clk (ab_cap_clk),
  .ba_cap_clk (ba_cap_clk),
  .ab_sel     (ab_sel),
  .ba_sel     (ba_sel),
  .b_drive    (b_drive),
  .a_drive_n  (a_drive_n),
  .a_in       (a_in),
  .a_out      (a_out),
  .a_oe       (a_oe),
  .b_in       (b_in),
  .b_out      (b_out),
  .b_oe       (b_oe)
);

// File: tb/tb_bidir_reg_xcvr.sv
module tb_bidir_reg_xcvr;

  localparam int W  = 8;
  localparam int NV = 12;
  localparam int VW = 4 + 2 + 2 * W + 2 + 2 * W;

  // {a_drive_n,b_drive,ab_sel,ba_sel, pulse_ab,pulse_ba, a_in,b_in, a_oe,b_oe, a_out,b_out}
  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    {4'b1000, 2'b11, 8'h3C, 8'hA5, 2'b00, 8'h00, 8'h00}, // R6 R1 R2 isolate+capture
    {4'b1100, 2'b00, 8'h5A, 8'hFF, 2'b01, 8'h00, 8'h5A}, // R3 R5 live to B
    {4'b1110, 2'b00, 8'h77, 8'hFF, 2'b01, 8'h00, 8'h3C}, // R4 stored to B
    {4'b0000, 2'b00, 8'h00, 8'hC3, 2'b10, 8'hC3, 8'h00}, // R3 R5 live to A
    {4'b0001, 2'b00, 8'h00, 8'hC3, 2'b10, 8'hA5, 8'h00}, // R4 stored to A
    {4'b0001, 2'b01, 8'h00, 8'h81, 2'b10, 8'h81, 8'h00}, // R2 capture while driving
    {4'b1110, 2'b10, 8'h96, 8'h00, 2'b01, 8'h00, 8'h96}, // R1 capture while driving
    {4'b0111, 2'b00, 8'h11, 8'h22, 2'b11, 8'h81, 8'h96}, // R8 both stored
    {4'b0100, 2'b00, 8'h4E, 8'h4E, 2'b11, 8'h4E, 8'h4E}, // R7 hold loop
    {4'b0101, 2'b00, 8'h12, 8'h34, 2'b11, 8'h81, 8'h12}, // R4 R3 mixed
    {4'b1110, 2'b01, 8'h00, 8'h96, 2'b01, 8'h00, 8'h96}, // R2 capture own drive
    {4'b0001, 2'b00, 8'h00, 8'h00, 2'b10, 8'h96, 8'h00}  // R2 shows captured
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ab_cap_clk, ba_cap_clk;
  logic         ab_sel, ba_sel, b_drive, a_drive_n;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out, ia_out, ib_out;
  logic         a_oe, b_oe, ia_oe, ib_oe;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  bidir_reg_xcvr #(.W(W), .INVERT(1'b0)) dut (
    .rst_n(rst_n), .ab_cap_clk(ab_cap_clk), .ba_cap_clk(ba_cap_clk),
    .ab_sel(ab_sel), .ba_sel(ba_sel), .b_drive(b_drive), .a_drive_n(a_drive_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  bidir_reg_xcvr #(.W(W), .INVERT(1'b1)) dut_inv (
    .rst_n(rst_n), .ab_cap_clk(ab_cap_clk), .ba_cap_clk(ba_cap_clk),
    .ab_sel(ab_sel), .ba_sel(ba_sel), .b_drive(b_drive), .a_drive_n(a_drive_n),
    .a_in(a_in), .a_out(ia_out), .a_oe(ia_oe),
    .b_in(b_in), .b_out(ib_out), .b_oe(ib_oe)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic eao, input logic ebo,
                           input logic [W-1:0] ea, input logic [W-1:0] eb);
    check({tag, " R5 a_oe"}, W'(a_oe), W'(eao));
    check({tag, " R5 b_oe"}, W'(b_oe), W'(ebo));
    check({tag, " a_out"}, a_out, ea);
    check({tag, " b_out"}, b_out, eb);
    check({tag, " R9 a_oe inv"}, W'(ia_oe), W'(eao));
    check({tag, " R9 b_oe inv"}, W'(ib_oe), W'(ebo));
    check({tag, " R9 a_out inv"}, ia_out, eao ? ~ea : '0);
    check({tag, " R9 b_out inv"}, ib_out, ebo ? ~eb : '0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; ab_cap_clk = 1'b0; ba_cap_clk = 1'b0;
    ab_sel = 1'b1; ba_sel = 1'b1; b_drive = 1'b1; a_drive_n = 1'b0;
    a_in = 8'hFF; b_in = 8'hFF;
    repeat (2) @(negedge clk);
    #1 check_all("R10 reset state", 1'b1, 1'b1, 8'h00, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {a_drive_n, b_drive, ab_sel, ba_sel} = VEC[i][VW-1 -: 4];
      a_in = VEC[i][VW-7 -: W];
      b_in = VEC[i][VW-7-W -: W];
      #1;
      ab_cap_clk = VEC[i][VW-5];
      ba_cap_clk = VEC[i][VW-6];
      #1;
      ab_cap_clk = 1'b0;
      ba_cap_clk = 1'b0;
      #1 check_all($sformatf("vec%0d", i), VEC[i][2*W+1], VEC[i][2*W],
                   VEC[i][2*W-1 -: W], VEC[i][W-1:0]);
    end

    // R6: registers still capture while isolated; both then seen via stored paths.
    @(negedge clk);
    {a_drive_n, b_drive, ab_sel, ba_sel} = 4'b1011;
    a_in = 8'hE7; b_in = 8'h18;
    #1 ab_cap_clk = 1'b1; ba_cap_clk = 1'b1;
    #1 ab_cap_clk = 1'b0; ba_cap_clk = 1'b0;
    #1 check_all("R6 isolated", 1'b0, 1'b0, 8'h00, 8'h00);
    a_drive_n = 1'b0; b_drive = 1'b1; a_in = 8'h00; b_in = 8'h00;
    #1 check_all("R6 R8 isolated capture", 1'b1, 1'b1, 8'h18, 8'hE7);

    // R3: live path follows input change with no clock edge.
    ab_sel = 1'b0; ba_sel = 1'b0;
    a_in = 8'h01; b_in = 8'h80;
    #1 check_all("R3 comb", 1'b1, 1'b1, 8'h80, 8'h01);

    // R10: asynchronous clear with no capture clock.
    ab_sel = 1'b1; ba_sel = 1'b1;
    #1 rst_n = 1'b0;
    #1 check_all("R10 async clear", 1'b1, 1'b1, 8'h00, 8'h00);
    rst_n = 1'b1;
    #1 check_all("R10 stays clear", 1'b1, 1'b1, 8'h00, 8'h00);

    finish_run();
  end

endmodule